// File: doc/BRIEF.md
# UART FIFO Service Request Generator

This block produces the service request for a UART whose transmit and receive FIFOs are 64 entries deep. It does not hold any character data. It watches the occupancy counts of the two FIFOs, the programmed trigger levels, and the push and pop strobes. From these it drives one interrupt line and two transmit status flags. The FIFO storage and the serial shifters sit outside the block.

A single mode bit selects how requests are raised:

- **Per-character mode.** Each receive push and each transmit pop latches a request. The request stays asserted until the host reads the status.
- **Block mode.** A request is raised only while the receive FIFO is filled past its trigger level, or while the transmit FIFO has drained below its trigger level. The host can then move a whole block of characters in one service.

The receive side and the transmit side each have an enable that gates their part of the interrupt. The transmit status flags report two conditions: room in the transmit FIFO, and a fully idle transmitter.

The interrupt is registered. The value of `irq` in a cycle reflects the inputs sampled at the previous rising clock edge. The status flags are combinational.

Top module: `uart_svc_irq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `irq` is 0.
- R2: In per-character mode (`fifo_en`=0, or `fifo_en`=1 with `blk_mode`=0), an `rx_push` sampled at an edge sets a receive request. With `rx_ien`=1, `irq` is 1 from the next cycle on and stays 1 until a status read.
- R3: In per-character mode, a `tx_pop` sampled at an edge sets a transmit request. With `tx_ien`=1, `irq` is 1 from the next cycle on and stays 1 until a status read.
- R4: A `stat_rd` sampled at an edge clears both per-character requests. A push or pop sampled at the same edge wins over the clear.
- R5: With `fifo_en`=1 and `blk_mode`=1, `irq` is 1 in the cycle after `tx_ien`=1 and `tx_count` < `tx_level` are sampled.
- R6: With `fifo_en`=1 and `blk_mode`=1, `irq` is 1 in the cycle after `rx_ien`=1 and `rx_count` > `rx_level` are sampled.
- R7: Each side's request reaches `irq` only while that side's enable was 1 at the sampling edge. With neither block condition enabled, `irq` is 0 in block mode.
- R8: With `fifo_en`=0, `blk_mode` is ignored and the block behaves in per-character mode. A threshold condition alone raises no request.
- R9: `thr_empty` is 1 when `tx_count` < 64 with `fifo_en`=1. With `fifo_en`=0 (single-entry holding), it is 1 only when `tx_count`=0.
- R10: `tx_idle` is 1 exactly when `tx_count`=0 and `tx_shift_busy`=0.
- R11: In block mode, `rx_push` and `tx_pop` set no request. They have no effect on `irq`, either during block mode or after a later return to per-character mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFOs enabled (0 = single-entry holding) |
| blk_mode | input | 1 | Request policy: 0 per-character, 1 block (control bit 3) |
| rx_ien | input | 1 | Receive request enable |
| tx_ien | input | 1 | Transmit request enable |
| rx_level | input | 6 | Receive trigger level |
| tx_level | input | 6 | Transmit trigger level |
| rx_count | input | 7 | Receive FIFO occupancy, 0 to 64 |
| tx_count | input | 7 | Transmit FIFO occupancy, 0 to 64 |
| rx_push | input | 1 | One character written into the receive FIFO |
| tx_pop | input | 1 | One character taken from the transmit FIFO |
| tx_shift_busy | input | 1 | Transmit shifter still holds a character |
| stat_rd | input | 1 | Host status read; clears per-character requests |
| irq | output | 1 | Service request, active high |
| thr_empty | output | 1 | Transmit FIFO has a free location (status bit 5) |
| tx_idle | output | 1 | Transmit FIFO and shifter both empty (status bit 6) |

## Verification
The assertions assume that both occupancy counts stay within 0 to 64. They also assume that the mode and enable inputs change only between clock edges. Under those assumptions, the value sampled at an edge is the value that the next cycle's `irq` depends on.

The bench drives every input at the falling edge and keeps each count within its legal range. The block-mode sweeps hold the push and pop strobes low, so the threshold properties are exercised without per-character requests mixed in. The per-character sequences clear any pending request with a status read before each new pattern.

// File: rtl/uart_svc_pkg.sv
package uart_svc_pkg;

  typedef enum logic {
    REQ_CHAR  = 1'b0,
    REQ_BLOCK = 1'b1
  } req_mode_e;

  // receive side wants service once filled past its level
  function automatic logic fill_past(input int unsigned cnt, input int unsigned lvl);
    return cnt > lvl;
  endfunction

  // transmit side wants service once drained below its level
  function automatic logic drain_below(input int unsigned cnt, input int unsigned lvl);
    return cnt < lvl;
  endfunction

  // free slot in the transmit path; single slot when FIFOs are off
  function automatic logic has_room(input int unsigned cnt, input int unsigned depth,
                                    input logic fifo_on);
    return fifo_on ? (cnt < depth) : (cnt == 0);
  endfunction

  function automatic req_mode_e pick_mode(input logic fifo_on, input logic blk);
    return (fifo_on && blk) ? REQ_BLOCK : REQ_CHAR;
  endfunction

endpackage

// File: rtl/svc_char_latch.sv
module svc_char_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag <= 1'b0;
    else if (arm && set_evt)   flag <= 1'b1;
    else if (clr_evt)          flag <= 1'b0;
  end
endmodule

// File: rtl/svc_level_cmp.sv
module svc_level_cmp #(
  parameter int unsigned CW    = 7,
  parameter int unsigned TW    = 6,
  parameter bit          ABOVE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [TW-1:0] level,
  output logic          hit
);
  import uart_svc_pkg::*;

  logic hit_d;

  generate
    if (ABOVE) begin : g_fill
      always_comb hit_d = fill_past(32'(count), 32'(level));
    end else begin : g_drain
      always_comb hit_d = drain_below(32'(count), 32'(level));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= hit_d;
  end
endmodule

// File: rtl/svc_line_status.sv
module svc_line_status #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = 7
) (
  input  logic          fifo_en,
  input  logic [CW-1:0] tx_count,
  input  logic          tx_shift_busy,
  output logic          thr_empty,
  output logic          tx_idle
);
  import uart_svc_pkg::*;

  always_comb begin
    thr_empty = has_room(32'(tx_count), DEPTH, fifo_en);
    tx_idle   = (tx_count == '0) && !tx_shift_busy;
  end
endmodule

// File: rtl/uart_svc_irq.sv
module uart_svc_irq #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned TW   = $clog2(DEPTH),
  localparam int unsigned CW   = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          blk_mode,
  input  logic          rx_ien,
  input  logic          tx_ien,
  input  logic [TW-1:0] rx_level,
  input  logic [TW-1:0] tx_level,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          rx_push,
  input  logic          tx_pop,
  input  logic          tx_shift_busy,
  input  logic          stat_rd,
  output logic          irq,
  output logic          thr_empty,
  output logic          tx_idle
);
  import uart_svc_pkg::*;

  // named events for the checker
  req_mode_e mode_now, mode_q;
  logic      char_arm;
  logic      rx_char_req, tx_char_req;
  logic      rx_blk_req, tx_blk_req;
  logic      rx_ien_q, tx_ien_q;
  logic      rx_side, tx_side;

  always_comb begin
    mode_now = pick_mode(fifo_en, blk_mode);
    char_arm = (mode_now == REQ_CHAR);
  end

  svc_char_latch u_rx_latch (
    .clk(clk), .rst_n(rst_n), .arm(char_arm),
    .set_evt(rx_push), .clr_evt(stat_rd), .flag(rx_char_req)
  );

  svc_char_latch u_tx_latch (
    .clk(clk), .rst_n(rst_n), .arm(char_arm),
    .set_evt(tx_pop), .clr_evt(stat_rd), .flag(tx_char_req)
  );

  svc_level_cmp #(.CW(CW), .TW(TW), .ABOVE(1'b1)) u_rx_cmp (
    .clk(clk), .rst_n(rst_n), .count(rx_count), .level(rx_level), .hit(rx_blk_req)
  );

  svc_level_cmp #(.CW(CW), .TW(TW), .ABOVE(1'b0)) u_tx_cmp (
    .clk(clk), .rst_n(rst_n), .count(tx_count), .level(tx_level), .hit(tx_blk_req)
  );

  svc_line_status #(.DEPTH(DEPTH), .CW(CW)) u_lsr (
    .fifo_en(fifo_en), .tx_count(tx_count), .tx_shift_busy(tx_shift_busy),
    .thr_empty(thr_empty), .tx_idle(tx_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= REQ_CHAR;
      rx_ien_q <= 1'b0;
      tx_ien_q <= 1'b0;
    end else begin
      mode_q   <= mode_now;
      rx_ien_q <= rx_ien;
      tx_ien_q <= tx_ien;
    end
  end

  always_comb begin
    rx_side = rx_ien_q && ((mode_q == REQ_BLOCK) ? rx_blk_req : rx_char_req);
    tx_side = tx_ien_q && ((mode_q == REQ_BLOCK) ? tx_blk_req : tx_char_req);
    irq     = rx_side || tx_side;
  end
endmodule

// File: rtl/svc_irq_chk.sv
module svc_irq_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned TW    = 6,
  parameter int unsigned CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          blk_mode,
  input logic          rx_ien,
  input logic          tx_ien,
  input logic [TW-1:0] rx_level,
  input logic [TW-1:0] tx_level,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_push,
  input logic          tx_pop,
  input logic          stat_rd,
  input logic          irq,
  input logic          thr_empty,
  input logic          tx_idle
);
  logic in_blk;
  assign in_blk = fifo_en && blk_mode;

  p_rst_quiet_r1: assert property (@(posedge clk) !rst_n |=> !irq);

  p_char_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_blk && rx_push && rx_ien) |=> irq);

  p_char_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_blk && tx_pop && tx_ien) |=> irq);

  p_char_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_blk && $past(!in_blk) && irq && !stat_rd && rx_ien == $past(rx_ien)
     && tx_ien == $past(tx_ien)) |=> irq);

  p_blk_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blk && tx_ien && (tx_count < CW'(tx_level))) |=> irq);

  p_blk_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blk && rx_ien && (rx_count > CW'(rx_level))) |=> irq);

  p_blk_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blk && !(rx_ien && rx_count > CW'(rx_level))
            && !(tx_ien && tx_count < CW'(tx_level))) |=> !irq);

  p_single_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && tx_count != '0) |-> !thr_empty);

  p_idle_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> (thr_empty && tx_count == '0));
endmodule

bind uart_svc_irq svc_irq_chk #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .blk_mode(blk_mode),
  .rx_ien(rx_ien), .tx_ien(tx_ien), .rx_level(rx_level), .tx_level(tx_level),
  .rx_count(rx_count), .tx_count(tx_count), .rx_push(rx_push), .tx_pop(tx_pop),
  .stat_rd(stat_rd), .irq(irq), .thr_empty(thr_empty), .tx_idle(tx_idle)
);

// File: tb/uart_svc_irq_bench.sv
module uart_svc_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0, blk_mode = 1'b0, rx_ien = 1'b0, tx_ien = 1'b0;
  logic [5:0] rx_level = '0, tx_level = '0;
  logic [6:0] rx_count = '0, tx_count = '0;
  logic       rx_push = 1'b0, tx_pop = 1'b0, tx_shift_busy = 1'b0, stat_rd = 1'b0;
  logic       irq, thr_empty, tx_idle;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  uart_svc_irq u_uart_svc_irq (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .blk_mode(blk_mode),
    .rx_ien(rx_ien), .tx_ien(tx_ien), .rx_level(rx_level), .tx_level(tx_level),
    .rx_count(rx_count), .tx_count(tx_count), .rx_push(rx_push), .tx_pop(tx_pop),
    .tx_shift_busy(tx_shift_busy), .stat_rd(stat_rd),
    .irq(irq), .thr_empty(thr_empty), .tx_idle(tx_idle)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one clock: registers take the inputs driven now; sample at the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_reqs();
    rx_push = 1'b0; tx_pop = 1'b0; stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 in reset", irq, 1'b0);
    step();
    rst_n = 1'b1;
    step();
    chk("R1 after reset", irq, 1'b0);

    // R2 receive per-character request latches until a status read
    fifo_en = 1'b1; blk_mode = 1'b0; rx_ien = 1'b1; tx_ien = 1'b1;
    rx_count = 7'd0; rx_level = 6'd0; tx_count = 7'd64; tx_level = 6'd0;
    step();
    chk("R2 idle", irq, 1'b0);
    rx_push = 1'b1; step(); rx_push = 1'b0;
    chk("R2 push", irq, 1'b1);
    for (int i = 0; i < 3; i++) begin step(); chk("R2 hold", irq, 1'b1); end
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
    chk("R4 clear rx", irq, 1'b0);

    // R3 transmit per-character request
    tx_pop = 1'b1; step(); tx_pop = 1'b0;
    chk("R3 pop", irq, 1'b1);
    step(); chk("R3 hold", irq, 1'b1);
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
    chk("R4 clear tx", irq, 1'b0);

    // R4 set wins over a coincident clear
    rx_push = 1'b1; stat_rd = 1'b1; step(); rx_push = 1'b0; stat_rd = 1'b0;
    chk("R4 set wins", irq, 1'b1);
    clear_reqs();
    chk("R4 cleared", irq, 1'b0);

    // R7 enables gate each per-character side
    rx_ien = 1'b0; tx_ien = 1'b1;
    rx_push = 1'b1; step(); rx_push = 1'b0;
    chk("R7 rx gated", irq, 1'b0);
    rx_ien = 1'b1; step();
    chk("R7 rx ungated", irq, 1'b1);
    clear_reqs();
    tx_ien = 1'b0;
    tx_pop = 1'b1; step(); tx_pop = 1'b0;
    chk("R7 tx gated", irq, 1'b0);
    clear_reqs();
    tx_ien = 1'b1;

    // R6 receive threshold sweep
    blk_mode = 1'b1; rx_ien = 1'b1; tx_ien = 1'b0;
    for (int lv = 0; lv < 64; lv++) begin
      for (int c = 0; c <= 64; c++) begin
        rx_level = 6'(lv); rx_count = 7'(c);
        step();
        chk("R6 rx threshold", irq, (c > lv) ? 1'b1 : 1'b0);
      end
    end

    // R5 transmit threshold sweep
    rx_ien = 1'b0; tx_ien = 1'b1;
    for (int lv = 0; lv < 64; lv++) begin
      for (int c = 0; c <= 64; c++) begin
        tx_level = 6'(lv); tx_count = 7'(c);
        step();
        chk("R5 tx threshold", irq, (c < lv) ? 1'b1 : 1'b0);
      end
    end

    // R7 block-mode gating: conditions true, enables off
    rx_count = 7'd64; rx_level = 6'd0; tx_count = 7'd0; tx_level = 6'd63;
    rx_ien = 1'b0; tx_ien = 1'b0; step();
    chk("R7 both gated", irq, 1'b0);
    rx_ien = 1'b1; step();
    chk("R7 rx only", irq, 1'b1);
    rx_ien = 1'b0; tx_ien = 1'b1; step();
    chk("R7 tx only", irq, 1'b1);

    // R11 strobes ignored in block mode
    rx_ien = 1'b1; tx_ien = 1'b1;
    rx_count = 7'd0; rx_level = 6'd63; tx_count = 7'd64; tx_level = 6'd0;
    rx_push = 1'b1; tx_pop = 1'b1; step(); rx_push = 1'b0; tx_pop = 1'b0;
    chk("R11 block strobes", irq, 1'b0);
    blk_mode = 1'b0; step();
    chk("R11 no stale request", irq, 1'b0);

    // R8 FIFOs off: block bit ignored
    fifo_en = 1'b0; blk_mode = 1'b1;
    rx_count = 7'd1; rx_level = 6'd0; tx_count = 7'd0; tx_level = 6'd10;
    step(); step();
    chk("R8 threshold ignored", irq, 1'b0);
    rx_push = 1'b1; step(); rx_push = 1'b0;
    chk("R8 per-char push", irq, 1'b1);
    clear_reqs();
    chk("R8 cleared", irq, 1'b0);

    // R9 and R10 status flags over all counts
    for (int fe = 0; fe < 2; fe++) begin
      for (int b = 0; b < 2; b++) begin
        for (int c = 0; c <= 64; c++) begin
          fifo_en = fe[0]; tx_shift_busy = b[0]; tx_count = 7'(c);
          #1;
          chk("R9 thr_empty", thr_empty, (fe == 1) ? ((c < 64) ? 1'b1 : 1'b0) : ((c == 0) ? 1'b1 : 1'b0));
          chk("R10 tx_idle", tx_idle, (c == 0 && b == 0) ? 1'b1 : 1'b0);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule